// File: doc/BRIEF.md
# Paired Set/Clear GPIO Bank Register

This block is a bank of up to eight general-purpose pins driven through a single 32-bit register word. Software never has to read the word, change a bit and write it back. Every action on a pin has its own trigger bit, and that bit does its work when written as 1. There is one trigger to pull the output latch low and one to pull it high. There is one trigger to enable the pad driver and one to release it. Bits written as 0 do nothing, so separate agents can control different pins of the same bank with plain writes and no locking.

Reading the word returns a snapshot of each pin: its output latch, its output enable and its synchronized input level. Pad inputs pass through a two-flop synchronizer before they reach the read path. A parameter sets the pin count. A bank with fewer than eight pins ignores the trigger bits of its absent pins and reads them as zero.

Top module: `gpio_pair_bank`

## Requirements
- R1: While rst_ni is low and after its release, every pad_oe_o and pad_out_o bit is 0, and rdata_o and rvalid_o are 0.
- R2: A write (wr_i high at a rising edge) with bit 2n set and bit 2n+1 clear makes pad_out_o[n] 0 from that edge on. With bit 2n+1 set and bit 2n clear, pad_out_o[n] becomes 1.
- R3: If bits 2n and 2n+1 are both 1 in one write, pad_out_o[n] keeps its value.
- R4: In a write, bit 16+2n alone sets pad_oe_o[n] to 1, and bit 17+2n alone clears it to 0.
- R5: If bits 16+2n and 17+2n are both 1 in one write, pad_oe_o[n] keeps its value.
- R6: Bits written as 0 change nothing. A pin whose four trigger bits are all 0 keeps its level and its direction, and nothing changes in cycles without wr_i.
- R7: rd_i high at an edge sets rvalid_o for the following cycle, and rdata_o then holds the read word. In that word, bit 2n is the output latch of pin n, bit 2n+1 is its synchronized input and bit 16+2n is its output enable. Bits 17+2n read as 0.
- R8: A change on pad_in_i[n] is not visible to a read captured at the first or second rising edge after the change. It is visible from the third edge on.
- R9: With NUM_PINS=4, trigger bits of pins 4 to 7 have no effect, and read bits 8 to 15 and 24 to 31 are 0.
- R10: A single write can carry a level trigger and the make-output trigger of the same pin. pad_out_o and pad_oe_o then change on the same edge. When the level is written first and make-output afterwards, the pad is enabled already holding the new level.
- R11: A read and a write in the same cycle return the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Trigger word |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read word, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS | Output latch per pin |
| pad_oe_o | output | NUM_PINS | Output enable per pin |

## Verification
A read can fall in the same cycle as a write that changes the very latches being read, and a pad input edge can arrive while a read is already in flight. The bench drives combined read-and-write cycles with random trigger words and expects the read word to match the model from before the write. It also changes inputs right before consecutive reads and expects the old level at the first two capture edges and the new level at the third. A 4-pin instance receives the same stimulus, and its masked result is compared against the same model.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CFG_LSB = 16;
  localparam int unsigned PIN_MAX = 8;

  typedef struct packed {
    logic drv_lo;
    logic drv_hi;
    logic mk_out;
    logic mk_in;
  } pin_cmd_t;

  function automatic pin_cmd_t decode_cmd(input logic [WORD_W-1:0] w, input int unsigned n);
    pin_cmd_t c;
    c.drv_lo = w[2*n];
    c.drv_hi = w[2*n+1];
    c.mk_out = w[CFG_LSB+2*n];
    c.mk_in  = w[CFG_LSB+2*n+1];
    return c;
  endfunction
endpackage

// File: rtl/gpio_pair_sync.sv
module gpio_pair_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_pair_pin.sv
module gpio_pair_pin
  import gpio_pair_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  pin_cmd_t cmd_i,
  output logic     out_o,
  output logic     oe_o
);
  logic out_q, oe_q;

  // opposing triggers in the same write cancel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (wr_i) begin
      if (cmd_i.drv_lo ^ cmd_i.drv_hi) out_q <= cmd_i.drv_hi;
      if (cmd_i.mk_out ^ cmd_i.mk_in)  oe_q  <= cmd_i.mk_out;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

  a_r2_drive_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.drv_hi && !cmd_i.drv_lo |=> out_o);
  a_r2_drive_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.drv_lo && !cmd_i.drv_hi |=> !out_o);
  a_r3_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.drv_lo && cmd_i.drv_hi |=> $stable(out_o));
  a_r4_make_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.mk_out && !cmd_i.mk_in |=> oe_o);
  a_r4_make_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.mk_in && !cmd_i.mk_out |=> !oe_o);
  a_r5_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.mk_out && cmd_i.mk_in |=> $stable(oe_o));
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(out_o) && $stable(oe_o));
endmodule

// File: rtl/gpio_pair_rdmux.sv
module gpio_pair_rdmux
  import gpio_pair_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] oe_i,
  input  logic [NUM_PINS-1:0] in_i,
  output logic [WORD_W-1:0]   word_o
);
  always_comb begin
    word_o = '0;
    for (int unsigned n = 0; n < NUM_PINS; n++) begin
      word_o[2*n]         = out_i[n];
      word_o[2*n+1]       = in_i[n];
      word_o[CFG_LSB+2*n] = oe_i[n];
    end
  end
endmodule

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank
  import gpio_pair_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [31:0]         wdata_i,
  input  logic                rd_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int unsigned USED_W = 2 * NUM_PINS;
  localparam logic [WORD_W-1:0] ZERO_MASK = ~(((WORD_W'(1) << USED_W) - 1) |
    (((WORD_W'(1) << USED_W) - 1) << CFG_LSB)) | {(WORD_W/2){2'b10}} & 32'hFFFF_0000;

  logic [NUM_PINS-1:0] in_sync;
  logic [WORD_W-1:0]   rd_word;

  gpio_pair_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_in_i),
    .sync_o (in_sync)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_cmd_t cmd;
    assign cmd = decode_cmd(wdata_i, n);
    gpio_pair_pin u_pin (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr_i),
      .cmd_i (cmd),
      .out_o (pad_out_o[n]),
      .oe_o  (pad_oe_o[n])
    );
  end

  gpio_pair_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .out_i (pad_out_o),
    .oe_i  (pad_oe_o),
    .in_i  (in_sync),
    .word_o(rd_word)
  );

  // snapshot taken before any same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_word;
    end
  end

  a_r7_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r7_rvalid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  a_r7_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o & ZERO_MASK) == '0);
  a_r11_read_pre_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_o[0] == $past(pad_out_o[0]) && rdata_o[CFG_LSB] == $past(pad_oe_o[0]));
endmodule

// File: tb/sim_gpio_pair_bank.sv
`timescale 1ns/1ps
module sim_gpio_pair_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wd = '0;
  logic [7:0]  pin = '0;
  logic [31:0] rdata0, rdata1;
  logic        rvalid0, rvalid1;
  logic [7:0]  out0, oe0;
  logic [3:0]  out1, oe1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] eo = '0, eoe = '0, ein = '0;

  always #4 clk = ~clk;

  gpio_pair_bank #(.NUM_PINS(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd), .rd_i(rd),
    .rdata_o(rdata0), .rvalid_o(rvalid0), .pad_in_i(pin),
    .pad_out_o(out0), .pad_oe_o(oe0));

  gpio_pair_bank #(.NUM_PINS(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd), .rd_i(rd),
    .rdata_o(rdata1), .rvalid_o(rvalid1), .pad_in_i(pin[3:0]),
    .pad_out_o(out1), .pad_oe_o(oe1));

  function automatic logic [31:0] build_rd(logic [7:0] o, logic [7:0] e, logic [7:0] i, int np);
    logic [31:0] w = '0;
    for (int n = 0; n < np; n++) begin
      w[2*n] = o[n]; w[2*n+1] = i[n]; w[16+2*n] = e[n];
    end
    return w;
  endfunction

  task automatic apply_wr(logic [31:0] d);
    for (int n = 0; n < 8; n++) begin
      if (d[2*n] != d[2*n+1]) eo[n] = d[2*n+1];
      if (d[16+2*n] != d[17+2*n]) eoe[n] = d[16+2*n];
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a negedge; one clock cycle per op
  task automatic op(logic w, logic [31:0] d, logic r, string req);
    logic [31:0] pre0, pre1;
    pre0 = build_rd(eo, eoe, ein, 8);
    pre1 = build_rd(eo, eoe, ein, 4);
    wr = w; wd = d; rd = r;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; wd = '0;
    if (w) apply_wr(d);
    chk({req, " pad_out u0"}, 32'(out0), 32'(eo));
    chk({req, " pad_oe u0"}, 32'(oe0), 32'(eoe));
    chk({req, " R9 pad_out u1"}, 32'(out1), 32'(eo[3:0]));
    chk({req, " R9 pad_oe u1"}, 32'(oe1), 32'(eoe[3:0]));
    chk({req, " R7 rvalid"}, 32'(rvalid0), 32'(r));
    if (r) begin
      chk({req, " rdata u0"}, rdata0, pre0);
      chk({req, " R9 rdata u1"}, rdata1, pre1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 out", 32'(out0), 0);
    chk("R1 oe", 32'(oe0), 0);
    chk("R1 rdata", rdata0, 0);
    chk("R1 rvalid", 32'(rvalid0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 0, 1'b1, "R1 after reset");

    // R2/R4 basic
    op(1'b1, 32'h0000_0002, 1'b0, "R2 pin0 high");
    op(1'b1, 32'h0000_0001, 1'b0, "R2 pin0 low");
    op(1'b1, 32'h0001_0000, 1'b0, "R4 pin0 out");
    op(1'b1, 32'h0002_0000, 1'b0, "R4 pin0 in");
    // R3/R5 both triggers
    op(1'b1, 32'h0010_0020, 1'b0, "R2 pin2 high out");
    op(1'b1, 32'h0030_0030, 1'b0, "R3 R5 pin2 hold");
    op(1'b0, 0, 1'b1, "R3 R5 readback");
    // R6 zero bits: others untouched
    op(1'b1, 32'h0000_8000, 1'b0, "R6 pin7 only");
    op(1'b1, 32'h0000_0000, 1'b1, "R6 zero write");
    // R10 level first, then make-output
    op(1'b1, 32'h0000_0080, 1'b0, "R10 pin3 level");
    chk("R10 pin3 still input", 32'(oe0[3]), 0);
    op(1'b1, 32'h0040_0000, 1'b0, "R10 pin3 enable");
    chk("R10 pin3 enabled high", 32'({oe0[3], out0[3]}), 32'b11);
    op(1'b1, 32'h0100_0200, 1'b0, "R10 pin4 combined");
    // R9 upper pins: u1 unaffected
    op(1'b1, 32'h5500_AA00, 1'b1, "R9 upper pins");
    op(1'b0, 0, 1'b1, "R9 readback");
    // R11 read with write
    op(1'b1, 32'hFFFF_5555, 1'b1, "R11 rd+wr");
    op(1'b1, 32'h5555_AAAA, 1'b1, "R11 rd+wr");
    // R8 synchronizer latency
    pin = 8'hA5;
    op(1'b0, 0, 1'b1, "R8 edge1 old");
    op(1'b0, 0, 1'b1, "R8 edge2 old");
    ein = 8'hA5;
    op(1'b0, 0, 1'b1, "R8 edge3 new");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      d = $urandom();
      if (k % 16 == 0) begin
        pin = 8'($urandom());
        op(1'b0, 0, 1'b0, "R8 settle");
        op(1'b0, 0, 1'b0, "R8 settle");
        ein = pin;
      end
      op(1'($urandom()), d, 1'($urandom()), "R2 R4 R6 R7 R11 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule